// File: doc/BRIEF.md
# Pulse-Width Lock Monitor

This block decides whether a phase-locked loop is in lock by timing the correction pulses of its edge-triggered phase-frequency detector. The up and down outputs of that detector are brought into a fast system clock domain, and the width of each correction pulse is counted in clock cycles. A pulse that stays at or above a programmable width limit is treated as a phase error that is too large. A narrow pulse, such as the detector's own short backlash glitch or the small corrections of a loop in lock, is ignored.

Two outputs come out. The raw indication stays high while every pulse is shorter than the limit and drops low once for each pulse that is too wide, so it pulses while the loop is out of lock. The steady flag comes from a retriggerable hold timer. Each too-wide pulse reloads the timer, and the flag rises only after the timer has run out with no new violation, so it gives a settled high level in lock and a settled low level out of lock. The width limit is supplied as a cycle count: the allowed phase error as a fraction of a full turn, multiplied by the input period and divided by the clock period.

Top module: `phase_lock_monitor`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `raw_lock` and `lock_flag` are 0, and the hold timer is loaded with `hold_cycles`.
- R2: `up_in` and `dn_in` each pass through a two-stage synchronizer. A pulse that violates a limit of 1, driven just before clock edge k, makes `raw_lock` low after edge k+2 and not before.
- R3: A run of consecutive synchronized cycles with up or down high that reaches `limit_cycles` cycles makes `raw_lock` go low in the cycle after it reaches the limit. Runs shorter than the limit leave `raw_lock` high.
- R4: The width count clears in any cycle where both synchronized inputs are low. A single low cycle between two short pulses therefore stops their widths from adding together.
- R5: Up and down are measured alike. Overlapping or back-to-back up and down activity counts as one continuous run.
- R6: Each cycle with `raw_lock` low reloads the hold timer with `hold_cycles`. `lock_flag` is 1 only when `raw_lock` is high and the timer has counted down to zero. After the last violation, `lock_flag` rises `hold_cycles` cycles after `raw_lock` returns high.
- R7: A `limit_cycles` of 0 holds `raw_lock` low, and so holds `lock_flag` low, from the next cycle on.
- R8: The width count saturates at 2^CNT_W-1. A pulse longer than that keeps `raw_lock` low for its whole length, and the count does not wrap.
- R9: With `hold_cycles` of 0, `lock_flag` follows `raw_lock` one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| up_in | input | 1 | Up pulse from the phase-frequency detector (asynchronous) |
| dn_in | input | 1 | Down pulse from the phase-frequency detector (asynchronous) |
| limit_cycles | input | CNT_W | Width limit in clock cycles; 0 forces not-locked |
| hold_cycles | input | HOLD_W | Hold window reloaded on each violation |
| raw_lock | output | 1 | High while no pulse reaches the limit |
| lock_flag | output | 1 | Steady lock level after the hold window |

## Verification
The bench builds the block with CNT_W = 6 and HOLD_W = 8, so a pulse of under a hundred cycles reaches the saturation value of 63 and the full range of hold windows can be covered in a short run. Limits from 0 to 12 and hold windows from 0 to 20 are drawn at random, which brings the zero-limit override, the zero-hold pass-through, and limits close to the typical pulse lengths within reach. The directed cases pin down the synchronizer latency, the one-cycle gap that restarts the count, and the overlapping up and down activity.

// File: rtl/plm_pkg.sv
package plm_pkg;

  typedef struct packed {
    logic up;
    logic dn;
  } pfd_pair_t;

  localparam int unsigned SYNC_DEPTH = 2;

endpackage

// File: rtl/plm_sync.sv
module plm_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned W      = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage_q[0] <= '0;
    else     stage_q[0] <= din;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[g] <= '0;
      else     stage_q[g] <= stage_q[g-1];
    end
  end

  assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/plm_width_meter.sv
module plm_width_meter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active,
  input  logic [CNT_W-1:0] limit,
  output logic             raw_ok
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] width_q;
  logic [CNT_W:0]   width_inc;
  logic             over_limit;

  assign width_inc  = {1'b0, width_q} + 1'b1;
  assign over_limit = (limit == '0) || (active && (width_inc >= {1'b0, limit}));

  always_ff @(posedge clk) begin
    if (rst) begin
      width_q <= '0;
      raw_ok  <= 1'b0;
    end else begin
      if (!active)                width_q <= '0;
      else if (width_q != CNT_MAX) width_q <= width_inc[CNT_W-1:0];
      raw_ok <= !over_limit;
    end
  end

  // R4: idle cycle clears the width count
  p_idle_clears_r4: assert property (@(posedge clk) disable iff (rst)
    !active |=> (width_q == '0));

  // R8: count holds at its ceiling while the pulse lasts
  p_saturate_r8: assert property (@(posedge clk) disable iff (rst)
    (active && width_q == CNT_MAX) |=> (width_q == CNT_MAX));

endmodule

// File: rtl/plm_hold_timer.sv
module plm_hold_timer #(
  parameter int unsigned HOLD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              violation,
  input  logic [HOLD_W-1:0] hold_load,
  output logic              steady
);

  logic [HOLD_W-1:0] hold_q;
  logic [HOLD_W-1:0] hold_d;

  always_comb begin
    if (violation)           hold_d = hold_load;
    else if (hold_q != '0)   hold_d = hold_q - 1'b1;
    else                     hold_d = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= hold_load;
      steady <= 1'b0;
    end else begin
      hold_q <= hold_d;
      steady <= !violation && (hold_d == '0);
    end
  end

  // R6: each violation reloads the window
  p_reload_r6: assert property (@(posedge clk) disable iff (rst)
    violation |=> (hold_q == $past(hold_load)));

  // R6: steady level only with an expired window
  p_flag_needs_zero_r6: assert property (@(posedge clk) disable iff (rst)
    steady |-> (hold_q == '0));

  // R6: quiet cycles count the window down by one
  p_count_down_r6: assert property (@(posedge clk) disable iff (rst)
    (!violation && hold_q != '0) |=> (hold_q == $past(hold_q) - 1'b1));

endmodule

// File: rtl/phase_lock_monitor.sv
module phase_lock_monitor #(
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned HOLD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              up_in,
  input  logic              dn_in,
  input  logic [CNT_W-1:0]  limit_cycles,
  input  logic [HOLD_W-1:0] hold_cycles,
  output logic              raw_lock,
  output logic              lock_flag
);

  import plm_pkg::*;

  localparam int unsigned PAIR_W = $bits(pfd_pair_t);

  pfd_pair_t pair_async;
  pfd_pair_t pair_sync;
  logic      pulse_active;

  assign pair_async.up = up_in;
  assign pair_async.dn = dn_in;

  plm_sync #(.STAGES(SYNC_DEPTH), .W(PAIR_W)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (pair_async),
    .dout (pair_sync)
  );

  assign pulse_active = pair_sync.up | pair_sync.dn;

  plm_width_meter #(.CNT_W(CNT_W)) u_meter (
    .clk    (clk),
    .rst    (rst),
    .active (pulse_active),
    .limit  (limit_cycles),
    .raw_ok (raw_lock)
  );

  plm_hold_timer #(.HOLD_W(HOLD_W)) u_hold (
    .clk       (clk),
    .rst       (rst),
    .violation (!raw_lock),
    .hold_load (hold_cycles),
    .steady    (lock_flag)
  );

  // R7: zero limit forces not-locked
  p_zero_limit_r7: assert property (@(posedge clk) disable iff (rst)
    (limit_cycles == '0) |=> !raw_lock);

  // R6: steady flag never high while raw indication is low
  p_flag_implies_raw_r6: assert property (@(posedge clk) disable iff (rst)
    lock_flag |-> $past(raw_lock));

endmodule

// File: tb/phase_lock_monitor_tb.sv
module phase_lock_monitor_tb;

  localparam int CW = 6;
  localparam int HW = 8;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic up_in = 1'b0, dn_in = 1'b0;
  logic [CW-1:0] limit_cycles = 6'd4;
  logic [HW-1:0] hold_cycles = 8'd10;
  logic raw_lock, lock_flag;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  phase_lock_monitor #(.CNT_W(CW), .HOLD_W(HW)) u_dut (
    .clk(clk), .rst(rst), .up_in(up_in), .dn_in(dn_in),
    .limit_cycles(limit_cycles), .hold_cycles(hold_cycles),
    .raw_lock(raw_lock), .lock_flag(lock_flag)
  );

  // reference model from the requirements
  bit m_u1, m_u2, m_d1, m_d2, m_raw, m_flag, m_act, m_vin, m_viol;
  int m_cnt, m_h, m_hn;

  function automatic bit exp_viol(bit act, int cnt, int lim);
    return (lim == 0) || (act && (cnt + 1 >= lim));
  endfunction

  function automatic int exp_hold(bit v, int h, int load);
    if (v) return load;
    return (h > 0) ? h - 1 : 0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_u1 = 0; m_u2 = 0; m_d1 = 0; m_d2 = 0;
      m_cnt = 0; m_raw = 0; m_flag = 0; m_h = int'(hold_cycles);
    end else begin
      m_act  = m_u2 | m_d2;
      m_vin  = !m_raw;
      m_viol = exp_viol(m_act, m_cnt, int'(limit_cycles));
      m_hn   = exp_hold(m_vin, m_h, int'(hold_cycles));
      m_flag = !m_vin && (m_hn == 0);
      m_h    = m_hn;
      m_raw  = !m_viol;
      m_cnt  = m_act ? ((m_cnt == CMAX) ? CMAX : m_cnt + 1) : 0;
      m_u2 = m_u1; m_u1 = up_in;
      m_d2 = m_d1; m_d1 = dn_in;
    end
  end

  task automatic expect_bit(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", tag, act, exp, $time);
    end
  endtask

  // one cycle; compare both outputs against the model away from the edge
  task automatic tick();
    @(negedge clk);
    expect_bit("R3 raw_lock", raw_lock, m_raw);
    expect_bit("R6 lock_flag", lock_flag, m_flag);
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic pulse(bit u, bit d, int len);
    up_in = u; dn_in = d;
    run(len);
    up_in = 0; dn_in = 0;
  endtask

  bit seen_low, seen_high;

  initial begin
    // R1: reset state
    run(3);
    expect_bit("R1 raw_lock in reset", raw_lock, 1'b0);
    expect_bit("R1 lock_flag in reset", lock_flag, 1'b0);
    rst = 0;
    tick();
    expect_bit("R1 lock_flag after reset", lock_flag, 1'b0);
    run(14);
    expect_bit("R6 flag after hold window", lock_flag, 1'b1);

    // R3: short pulses ignored
    seen_low = 0;
    up_in = 1; for (int i = 0; i < 3; i++) begin tick(); seen_low |= !raw_lock; end
    up_in = 0; for (int i = 0; i < 6; i++) begin tick(); seen_low |= !raw_lock; end
    expect_bit("R3 short pulse ignored", seen_low, 1'b0);

    // R3: pulse at the limit
    seen_low = 0;
    up_in = 1; for (int i = 0; i < 4; i++) begin tick(); seen_low |= !raw_lock; end
    up_in = 0; for (int i = 0; i < 4; i++) begin tick(); seen_low |= !raw_lock; end
    expect_bit("R3 pulse at limit detected", seen_low, 1'b1);
    expect_bit("R6 flag dropped", lock_flag, 1'b0);
    run(16);
    expect_bit("R6 flag recovers", lock_flag, 1'b1);

    // R4: a one-cycle gap restarts the count
    seen_low = 0;
    for (int k = 0; k < 2; k++) begin
      dn_in = 1; for (int i = 0; i < 3; i++) begin tick(); seen_low |= !raw_lock; end
      dn_in = 0; tick(); seen_low |= !raw_lock;
    end
    for (int i = 0; i < 4; i++) begin tick(); seen_low |= !raw_lock; end
    expect_bit("R4 gap clears width", seen_low, 1'b0);

    // R5: up then overlapping down forms one run
    seen_low = 0;
    up_in = 1; run(2); dn_in = 1; tick(); up_in = 0; tick(); dn_in = 0;
    for (int i = 0; i < 5; i++) begin tick(); seen_low |= !raw_lock; end
    expect_bit("R5 combined run detected", seen_low, 1'b1);
    run(16);

    // R2: latency through the synchronizer with limit 1
    limit_cycles = 6'd1;
    up_in = 1; tick(); up_in = 0;
    expect_bit("R2 no change after first edge", raw_lock, 1'b1);
    tick();
    expect_bit("R2 no change after second edge", raw_lock, 1'b1);
    tick();
    expect_bit("R2 drop after third edge", raw_lock, 1'b0);
    run(16);

    // R8: long pulse saturates and keeps raw low
    limit_cycles = 6'd4;
    up_in = 1; run(6);
    seen_high = 0;
    for (int i = 0; i < 80; i++) begin tick(); seen_high |= raw_lock; end
    up_in = 0;
    expect_bit("R8 raw low through long pulse", seen_high, 1'b0);
    run(16);

    // R7: zero limit
    limit_cycles = 6'd0; run(2);
    expect_bit("R7 raw forced low", raw_lock, 1'b0);
    run(20);
    expect_bit("R7 flag forced low", lock_flag, 1'b0);
    limit_cycles = 6'd5; run(16);

    // R9: zero hold window
    hold_cycles = 8'd0; run(3);
    pulse(1, 0, 8);
    seen_low = 0;
    for (int i = 0; i < 10; i++) begin
      tick();
      if (lock_flag !== m_flag) seen_low = 1;
    end
    expect_bit("R9 flag follows raw", seen_low, 1'b0);

    // random phase: mixed pulse trains, compared cycle by cycle
    void'($urandom(32'h5eed_1234));
    for (int seg = 0; seg < 600; seg++) begin
      if (($urandom % 40) == 0) limit_cycles = CW'($urandom % 13);
      if (($urandom % 30) == 0) hold_cycles  = HW'($urandom % 21);
      up_in = $urandom % 2;
      dn_in = ($urandom % 3) == 0;
      run(1 + ($urandom % 8));
      up_in = 0; dn_in = 0;
      run($urandom % 6);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule